// File: doc/BRIEF.md
# Sparse Weight Stream Expander

The block feeds an integer multiply-accumulate datapath from a compressed weight store. Zero-valued weights are not kept in memory, so the weight stream carries only the nonzero values. A separate occupancy bitmask, delivered as its own stream of words, says for each element position whether a stored weight exists. The block walks the mask one element per cycle. For every element it takes one activation from a dense activation stream, and it takes one weight from the compressed stream only where the mask says a weight is present.

There are two modes. In skip mode, elements without a weight are dropped, so the datapath sees one (weight, activation) pair per stored weight and the number of MAC operations falls with the sparsity ratio. In expand mode a zero weight is put back at every empty position, so the pairs keep the dense activation order. A programmable element count sets the length of a block, and the final pair of each block carries an end flag. All four streams use valid/ready handshakes.

Top module: `sparse_weight_expander`

## Requirements
- R1: A mask word is 32 bits and is read least significant bit first: bit k covers the k-th element the word describes. A 1 means a stored weight is present and a 0 means the weight is zero. After reset there is no output, `mask_ready_o` is high, and both `act_ready_o` and `wgt_ready_o` are low.
- R2: Each element takes exactly one activation in both modes. A weight is taken only for an element whose mask bit is 1, and always in the same cycle as that element's activation.
- R3: With `mode_i`=0 (skip), exactly one pair is produced for each element whose bit is 1, as (stored weight, activation), in element order. Elements whose bit is 0 produce nothing.
- R4: With `mode_i`=1 (expand), exactly one pair is produced for every element, in element order. The weight field is 0 for each element whose bit is 0.
- R5: A block is `elem_cnt_i` elements long (at least 1, held stable for the whole block). Mask bits beyond the end of a block in its last word are discarded, and the next block starts on a fresh mask word.
- R6: `out_last_o` is 1 on the last pair of each block and 0 on every other pair. In skip mode this holds even when the block ends with elements whose bit is 0. A skip-mode block with no bit set produces no pair.
- R7: While `out_valid_o` is high and `out_ready_i` is low, the valid signal, weight, activation and last flag stay unchanged. No input item is lost or duplicated under any pattern of backpressure.
- R8: In skip mode, an element whose bit is 0 takes its activation without waiting for `out_ready_i`. A run of such elements, including a whole all-zero mask word, drains at one activation per cycle while the output is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = skip, 1 = expand; stable within a block |
| elem_cnt_i | input | CNT_W | Elements per block, at least 1 |
| mask_valid_i | input | 1 | Mask word valid |
| mask_data_i | input | MASK_W | Occupancy mask word, LSB first |
| mask_ready_o | output | 1 | Mask word accepted |
| wgt_valid_i | input | 1 | Compressed weight valid |
| wgt_data_i | input | WGT_W | Nonzero weight |
| wgt_ready_o | output | 1 | Weight accepted |
| act_valid_i | input | 1 | Activation valid |
| act_data_i | input | ACT_W | Dense activation |
| act_ready_o | output | 1 | Activation accepted |
| out_valid_o | output | 1 | Pair valid |
| out_ready_i | input | 1 | Downstream accepts pair |
| out_wgt_o | output | WGT_W | Pair weight |
| out_act_o | output | ACT_W | Pair activation |
| out_last_o | output | 1 | Last pair of the block |

## Verification
The hardest case to reach is a pair sitting in the output holding slot while the output is stalled and a trailing run of empty skip-mode elements closes the block. The activations must still drain, and the held pair must become valid with its end flag set without ever seeing a ready. The bench gets there by forcing `out_ready_i` low and sending a skip block whose single set bit is its first element, followed by 31 clear bits, and then checks the activation stream and the output flags at the ports before it releases the stall. A second stalled block with an all-zero mask checks that empty elements drain with no output at all. Back-to-back blocks whose last mask words have junk ones above the block end show whether those bits are discarded.

// File: rtl/swe_pkg.sv
`timescale 1ns/1ps
package swe_pkg;
  typedef enum logic {
    MODE_SKIP   = 1'b0,
    MODE_EXPAND = 1'b1
  } swe_mode_e;
endpackage

// File: rtl/swe_mask_reg.sv
`timescale 1ns/1ps
module swe_mask_reg #(
  parameter int unsigned MASK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MASK_W-1:0] word_i,
  input  logic              step_i,
  input  logic              close_i,
  output logic              vld_o,
  output logic              bit_o,
  output logic              word_end_o
);
  localparam int unsigned IDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MASK_W - 1);

  logic [MASK_W-1:0] mask_q;
  logic [IDX_W-1:0]  idx_q;
  logic              vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      idx_q  <= '0;
      vld_q  <= 1'b0;
    end else if (load_i) begin
      mask_q <= word_i;
      idx_q  <= '0;
      vld_q  <= 1'b1;
    end else if (step_i) begin
      if (close_i) begin
        vld_q <= 1'b0;
        idx_q <= '0;
      end else begin
        mask_q <= mask_q >> 1;
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign vld_o      = vld_q;
  assign bit_o      = mask_q[0];
  assign word_end_o = (idx_q == LAST_IDX);
endmodule

// File: rtl/swe_blk_cnt.sv
`timescale 1ns/1ps
module swe_blk_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             final_o
);
  logic [CNT_W-1:0] pos_q;

  assign final_o = (pos_q == cnt_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (step_i) pos_q <= final_o ? '0 : pos_q + 1'b1;
  end
endmodule

// File: rtl/swe_pair_hold.sv
`timescale 1ns/1ps
module swe_pair_hold #(
  parameter int unsigned WGT_W = 8,
  parameter int unsigned ACT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WGT_W-1:0] push_wgt_i,
  input  logic [ACT_W-1:0] push_act_i,
  input  logic             push_last_i,
  input  logic             mark_last_i,
  input  logic             pop_i,
  output logic             vld_o,
  output logic [WGT_W-1:0] wgt_o,
  output logic [ACT_W-1:0] act_o,
  output logic             last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      wgt_o  <= '0;
      act_o  <= '0;
      last_o <= 1'b0;
    end else if (push_i) begin
      vld_o  <= 1'b1;
      wgt_o  <= push_wgt_i;
      act_o  <= push_act_i;
      last_o <= push_last_i;
    end else if (pop_i) begin
      vld_o  <= 1'b0;
      last_o <= 1'b0;
    end else if (mark_last_i && vld_o) begin
      // trailing empty elements close the block on the held pair
      last_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sparse_weight_expander.sv
`timescale 1ns/1ps
module sparse_weight_expander
  import swe_pkg::*;
#(
  parameter int unsigned WGT_W  = 8,
  parameter int unsigned ACT_W  = 8,
  parameter int unsigned MASK_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [CNT_W-1:0]  elem_cnt_i,
  input  logic              mask_valid_i,
  input  logic [MASK_W-1:0] mask_data_i,
  output logic              mask_ready_o,
  input  logic              wgt_valid_i,
  input  logic [WGT_W-1:0]  wgt_data_i,
  output logic              wgt_ready_o,
  input  logic              act_valid_i,
  input  logic [ACT_W-1:0]  act_data_i,
  output logic              act_ready_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WGT_W-1:0]  out_wgt_o,
  output logic [ACT_W-1:0]  out_act_o,
  output logic              out_last_o
);
  logic m_vld, m_bit, m_word_end;
  logic blk_final;
  logic h_vld, h_last;
  logic emit, can_enter, w_ok, o_ok;
  logic step, push, mark, pop, close, pair_avail, load;
  logic [WGT_W-1:0] push_wgt;

  assign emit       = m_bit | (swe_mode_e'(mode_i) == MODE_EXPAND);
  assign can_enter  = ~h_vld | out_ready_i;
  assign w_ok       = ~m_bit | wgt_valid_i;
  assign o_ok       = ~emit | can_enter;

  assign step       = m_vld & act_valid_i & w_ok & o_ok;
  assign push       = step & emit;
  assign mark       = step & ~emit & blk_final;
  assign close      = m_word_end | blk_final;
  assign pair_avail = m_vld & emit & act_valid_i & w_ok;

  assign act_ready_o  = m_vld & w_ok & o_ok;
  assign wgt_ready_o  = m_vld & m_bit & act_valid_i & o_ok;
  assign mask_ready_o = ~m_vld | (step & close);
  assign load         = mask_valid_i & mask_ready_o;

  // held pair leaves once its successor is ready or the block is closed
  assign out_valid_o = h_vld & (h_last | pair_avail);
  assign pop         = out_valid_o & out_ready_i;
  assign out_last_o  = h_last;
  assign push_wgt    = m_bit ? wgt_data_i : '0;

  swe_mask_reg #(.MASK_W(MASK_W)) u_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .word_i     (mask_data_i),
    .step_i     (step),
    .close_i    (close),
    .vld_o      (m_vld),
    .bit_o      (m_bit),
    .word_end_o (m_word_end)
  );

  swe_blk_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .cnt_i   (elem_cnt_i),
    .final_o (blk_final)
  );

  swe_pair_hold #(.WGT_W(WGT_W), .ACT_W(ACT_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_wgt_i  (push_wgt),
    .push_act_i  (act_data_i),
    .push_last_i (blk_final),
    .mark_last_i (mark),
    .pop_i       (pop),
    .vld_o       (h_vld),
    .wgt_o       (out_wgt_o),
    .act_o       (out_act_o),
    .last_o      (h_last)
  );
endmodule

// File: rtl/swe_checker.sv
`timescale 1ns/1ps
module swe_checker #(
  parameter int unsigned WGT_W = 8,
  parameter int unsigned ACT_W = 8,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic [CNT_W-1:0] elem_cnt_i,
  input logic             wgt_valid_i,
  input logic             wgt_ready_o,
  input logic             act_valid_i,
  input logic             act_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [WGT_W-1:0] out_wgt_o,
  input logic [ACT_W-1:0] out_act_o,
  input logic             out_last_o
);
  logic             out_fire, wgt_fire;
  logic [CNT_W-1:0] pairs_q;
  logic [3:0]       owed_q;

  assign out_fire = out_valid_o & out_ready_i;
  assign wgt_fire = wgt_valid_i & wgt_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pairs_q <= '0;
      owed_q  <= '0;
    end else begin
      if (out_fire && mode_i) pairs_q <= out_last_o ? '0 : pairs_q + 1'b1;
      if (!mode_i) begin
        if (wgt_fire && !out_fire)      owed_q <= owed_q + 1'b1;
        else if (out_fire && !wgt_fire) owed_q <= owed_q - 1'b1;
      end
    end
  end

  p_out_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_wgt_o)
      && $stable(out_act_o) && $stable(out_last_o));

  p_wgt_with_act_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wgt_fire |-> act_valid_i && act_ready_o);

  p_pair_has_wgt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && !mode_i |-> owed_q != 0);

  p_expand_span_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && mode_i && out_last_o |-> pairs_q == elem_cnt_i - CNT_W'(1));

  p_cnt_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elem_cnt_i != '0);
endmodule

bind sparse_weight_expander swe_checker #(
  .WGT_W(WGT_W), .ACT_W(ACT_W), .CNT_W(CNT_W)
) u_swe_chk (.*);

// File: tb/sparse_weight_expander_tb_top.sv
`timescale 1ns/1ps
module sparse_weight_expander_tb_top;
  localparam int WW = 8, AW = 8, MW = 32, CW = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic          mode_i = 1'b0;
  logic [CW-1:0] elem_cnt_i = 16'd1;
  logic          mask_valid_i = 1'b0, wgt_valid_i = 1'b0, act_valid_i = 1'b0;
  logic [MW-1:0] mask_data_i = '0;
  logic [WW-1:0] wgt_data_i = '0;
  logic [AW-1:0] act_data_i = '0;
  logic          out_ready_i = 1'b0;
  logic          mask_ready_o, wgt_ready_o, act_ready_o, out_valid_o, out_last_o;
  logic [WW-1:0] out_wgt_o;
  logic [AW-1:0] out_act_o;

  sparse_weight_expander #(.WGT_W(WW), .ACT_W(AW), .MASK_W(MW), .CNT_W(CW)) dut_i (.*);

  logic [MW-1:0]    mq[$];
  logic [WW-1:0]    wq[$];
  logic [AW-1:0]    aq[$];
  logic [WW+AW:0]   eq[$];
  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    hold_lo = 0, slow = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint actv, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, actv, expv);
    end
  endtask

  // feeders: valid held until accepted
  initial begin : feed_mask
    bit took = 0;
    forever begin
      @(negedge clk_i);
      if (took) begin void'(mq.pop_front()); mask_valid_i = 0; took = 0; end
      if (rst_ni && !mask_valid_i && mq.size() > 0 && $urandom_range(0, 3) != 0) begin
        mask_valid_i = 1; mask_data_i = mq[0];
      end
      #9 took = mask_valid_i && mask_ready_o;
    end
  end

  initial begin : feed_wgt
    bit took = 0;
    forever begin
      @(negedge clk_i);
      if (took) begin void'(wq.pop_front()); wgt_valid_i = 0; took = 0; end
      if (rst_ni && !wgt_valid_i && wq.size() > 0 && $urandom_range(0, 3) != 0) begin
        wgt_valid_i = 1; wgt_data_i = wq[0];
      end
      #9 took = wgt_valid_i && wgt_ready_o;
    end
  end

  initial begin : feed_act
    bit took = 0;
    forever begin
      @(negedge clk_i);
      if (took) begin void'(aq.pop_front()); act_valid_i = 0; took = 0; end
      if (rst_ni && !act_valid_i && aq.size() > 0 && $urandom_range(0, 4) != 0) begin
        act_valid_i = 1; act_data_i = aq[0];
      end
      #9 took = act_valid_i && act_ready_o;
    end
  end

  // monitor / scoreboard
  initial begin : monitor
    logic [WW+AW:0] e;
    forever begin
      @(negedge clk_i);
      if (hold_lo)   out_ready_i = 0;
      else if (slow) out_ready_i = ($urandom_range(0, 3) == 0);
      else           out_ready_i = ($urandom_range(0, 3) != 0);
      #9;
      if (out_valid_o && out_ready_i) begin
        if (eq.size() == 0)
          check(0, cur_req, "unexpected pair", {out_last_o, out_wgt_o, out_act_o}, 0);
        else begin
          e = eq.pop_front();
          check({out_last_o, out_wgt_o, out_act_o} == e, cur_req, "pair",
                {out_last_o, out_wgt_o, out_act_o}, e);
        end
      end
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog %s actual=hung expected=done", cur_req);
    summary();
    $finish;
  end

  // expected pairs come from the mask alone (R1, R3, R4, R6)
  task automatic load_block(input logic m, input int n, input logic [127:0] pres,
                            input logic [127:0] junk);
    int nw = (n + 31) / 32;
    int lastidx = -1;
    mode_i = m;
    elem_cnt_i = CW'(n);
    for (int i = 0; i < n; i++) if (m || pres[i]) lastidx = i;
    for (int k = 0; k < nw; k++) begin
      logic [MW-1:0] wd;
      for (int j = 0; j < MW; j++) wd[j] = (k * 32 + j < n) ? pres[k * 32 + j] : junk[k * 32 + j];
      mq.push_back(wd);
    end
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a = AW'($urandom_range(0, 255));
      logic [WW-1:0] w = pres[i] ? WW'($urandom_range(1, 255)) : '0;
      aq.push_back(a);
      if (pres[i]) wq.push_back(w);
      if (m || pres[i]) eq.push_back({(i == lastidx), w, a});
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 5000 && (mq.size() + wq.size() + aq.size() + eq.size()) > 0; i++)
      @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    // R2: every activation and weight taken, nothing extra
    check(mq.size() + wq.size() + aq.size() + eq.size() == 0, cur_req, "R2 block drained",
          mq.size() + wq.size() + aq.size() + eq.size(), 0);
    check(out_valid_o == 0, cur_req, "R2 idle after block", out_valid_o, 0);
  endtask

  task automatic wait_acts();
    for (int i = 0; i < 200 && aq.size() > 0; i++) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  initial begin : main
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    check(out_valid_o == 0, "R1", "reset out_valid", out_valid_o, 0);
    check(mask_ready_o == 1, "R1", "reset mask_ready", mask_ready_o, 1);
    check(act_ready_o == 0 && wgt_ready_o == 0, "R1", "reset act/wgt ready",
          {act_ready_o, wgt_ready_o}, 0);

    cur_req = "R4"; // expand, partial second word, junk ones above end (R5)
    load_block(1, 40, {$urandom, $urandom, $urandom, $urandom}, '1);
    drain();

    cur_req = "R3"; // skip, random occupancy
    load_block(0, 40, {$urandom, $urandom, $urandom, $urandom}, '1);
    drain();

    cur_req = "R6"; // skip, trailing empty elements
    load_block(0, 5, 128'b00101, '1);
    drain();

    cur_req = "R4"; // expand, single empty element
    load_block(1, 1, 128'h0, '1);
    drain();

    cur_req = "R6"; // skip, no weight at all: no pair
    load_block(0, 10, 128'h0, '1);
    drain();

    cur_req = "R5"; // back to back blocks, junk above end must be dropped
    load_block(0, 7, 128'b1011001, '1);
    load_block(0, 7, 128'b1110100, '1);
    drain();

    cur_req = "R8"; // all-zero word with output stalled
    hold_lo = 1;
    @(negedge clk_i);
    load_block(0, 32, 128'h0, '0);
    wait_acts();
    check(aq.size() == 0, "R8", "acts drained under stall", aq.size(), 0);
    check(out_valid_o == 0, "R8", "no pair from empty word", out_valid_o, 0);
    hold_lo = 0;
    drain();

    cur_req = "R8"; // held pair, trailing empty run, output stalled
    hold_lo = 1;
    @(negedge clk_i);
    load_block(0, 32, 128'h1, '0);
    wait_acts();
    check(aq.size() == 0, "R8", "empty run drained past held pair", aq.size(), 0);
    check(out_valid_o == 1 && out_last_o == 1, "R6", "held pair closes block",
          {out_valid_o, out_last_o}, 2'b11);
    hold_lo = 0;
    drain();

    cur_req = "R7"; // heavy backpressure, two full words
    slow = 1;
    load_block(0, 64, {$urandom, $urandom, $urandom, $urandom}, '0);
    drain();
    load_block(1, 33, {$urandom, $urandom, $urandom, $urandom}, '1);
    drain();
    slow = 0;

    cur_req = "R3"; // dense skip block
    load_block(0, 20, '1, '0);
    drain();

    summary();
    $finish;
  end
endmodule